// File: doc/BRIEF.md
# Power-Loss Cache Backup Sequencer

This block protects a volatile write cache when main power fails. While power is good it stays quiet. It watches the power-good, host clock-enable and cache-dirty inputs and holds its memory-bus drive enable low, so the host controller owns the bus alone. If power drops while the cache holds uncommitted data, the block waits for the host to release the bus. The host shows the release by lowering its clock-enable. The block then takes the bus and copies every cache word into a non-volatile store. After the final word it writes a validity marker.

When power returns, the block checks the marker. If the marker is present, it waits again for the host clock-enable to be low, then copies the saved image back into volatile memory and clears the marker. Only then does it release the bus and raise its done flag. Both memories and the marker are modelled as request/acknowledge ports: a request stays high until a single-cycle acknowledge. Each word is 72 bits wide, made of 64 data bits with 8 check bits in bits 71:64, and it passes through unaltered.

Top module: `cache_backup_seq`

## Requirements
- R1: While `done_o` is high, no request on any port is active and `bus_oe_o` is low. After a power-up with no saved image, `done_o` rises within three cycles of reset release.
- R2: `bus_oe_o` is low during reset, while idle and after a backup ends. No request is ever active while `bus_oe_o` is low.
- R3: `bus_oe_o` never rises unless `host_cke_i` was low at the clock edge before. This holds for both backup and restore, and the block waits indefinitely while `host_cke_i` stays high.
- R4: A backup reads volatile addresses 0 up to `LAST_ADDR` in ascending order. Each read is followed by a non-volatile write to the same address.
- R5: The word address moves forward only after both the read acknowledge and the write acknowledge for the current word have been received.
- R6: Every word written is bit-for-bit equal to the word just read, including the check bits [71:64].
- R7: If `dirty_n_i` is high (clean) when power-good falls, no transfer takes place, `bus_oe_o` stays low and `done_o` drops. The block waits for power-good to return.
- R8: After the write of the last backup word, exactly one marker write with `mk_val_o`=1 is issued, and it is the last transaction of the backup.
- R9: At power-up with the marker present, the block reads non-volatile addresses 0 to `LAST_ADDR` and writes each word to the same volatile address. It then writes the marker with `mk_val_o`=0 and returns to idle with `done_o` high.
- R10: At power-up with the marker absent, the block goes straight to idle with `done_o` high and makes no transfer.
- R11: If power-good returns during a backup, the backup still completes, marker included, and a full restore then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Main power good |
| host_cke_i | input | 1 | Host clock-enable; high while the host drives the bus |
| dirty_n_i | input | 1 | Active-low: cache holds uncommitted writes |
| bus_oe_o | output | 1 | Drive enable of the block's memory-bus outputs (low = high impedance) |
| done_o | output | 1 | Block idle, bus released, cache valid for host |
| vm_req_o | output | 1 | Volatile memory request |
| vm_we_o | output | 1 | Volatile memory write (1) or read (0) |
| vm_addr_o | output | ADDR_W | Volatile memory word address |
| vm_wdata_o | output | WORD_W | Volatile memory write word |
| vm_ack_i | input | 1 | Volatile memory acknowledge |
| vm_rdata_i | input | WORD_W | Volatile memory read word, valid with acknowledge |
| nv_req_o | output | 1 | Non-volatile store request |
| nv_we_o | output | 1 | Non-volatile write (1) or read (0) |
| nv_addr_o | output | ADDR_W | Non-volatile word address |
| nv_wdata_o | output | WORD_W | Non-volatile write word |
| nv_ack_i | input | 1 | Non-volatile acknowledge |
| nv_rdata_i | input | WORD_W | Non-volatile read word, valid with acknowledge |
| mk_req_o | output | 1 | Marker write request |
| mk_val_o | output | 1 | Marker value to write |
| mk_ack_i | input | 1 | Marker write acknowledge |
| mk_present_i | input | 1 | Stored marker value |

## Verification
The sequencer is exercised with five patterns:
- a plain power-up with no saved image;
- a dirty power loss in which the host holds clock-enable high for several cycles;
- a power-up restore, again delayed by clock-enable;
- a clean power loss;
- a dirty power loss in which power-good comes back after a few words.

The clean loss tells the dirty-flag gating apart from an unconditional backup. The delayed clock-enable cases separate a correct handoff from one that drives the bus early. The early power return shows whether a backup can be cut short. Memory latencies vary with the address, so the order of the handshakes, not their timing, decides each compared transaction, and the word patterns make every check bit distinct per address.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int WORD_W = DATA_W + CHK_W;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_IDLE,
        ST_OFF,
        ST_HOLD,
        ST_BK_RD,
        ST_BK_WR,
        ST_BK_MARK,
        ST_BK_END,
        ST_RS_RD,
        ST_RS_WR,
        ST_RS_CLR
    } cbs_state_e;

    typedef struct packed {
        cbs_state_e state;
        logic       own;
    } cbs_ctl_t;
endpackage

// File: rtl/cbs_word_ctr.sv
module cbs_word_ctr #(
    parameter int ADDR_W    = 16,
    parameter int LAST_ADDR = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] LAST_W = ADDR_W'(LAST_ADDR);

    logic [ADDR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (adv)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign addr_o = cnt_q;
    assign last_o = (cnt_q == LAST_W);

    // R4: the sweep never steps past the last address
    p_no_pass_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |-> (addr_o != LAST_W));
endmodule

// File: rtl/cbs_word_buf.sv
module cbs_word_buf #(
    parameter int WORD_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] d_i,
    output logic [WORD_W-1:0] q_o
);
    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load) word_d = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign q_o = word_q;
endmodule

// File: rtl/cache_backup_seq.sv
module cache_backup_seq
    import cbs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LAST_ADDR = 255,
    parameter int WORD_W    = cbs_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good_i,
    input  logic              host_cke_i,
    input  logic              dirty_n_i,
    output logic              bus_oe_o,
    output logic              done_o,
    output logic              vm_req_o,
    output logic              vm_we_o,
    output logic [ADDR_W-1:0] vm_addr_o,
    output logic [WORD_W-1:0] vm_wdata_o,
    input  logic              vm_ack_i,
    input  logic [WORD_W-1:0] vm_rdata_i,
    output logic              nv_req_o,
    output logic              nv_we_o,
    output logic [ADDR_W-1:0] nv_addr_o,
    output logic [WORD_W-1:0] nv_wdata_o,
    input  logic              nv_ack_i,
    input  logic [WORD_W-1:0] nv_rdata_i,
    output logic              mk_req_o,
    output logic              mk_val_o,
    input  logic              mk_ack_i,
    input  logic              mk_present_i
);
    localparam logic [ADDR_W-1:0] LAST_W = ADDR_W'(LAST_ADDR);

    cbs_ctl_t          ctl_d, ctl_q;
    logic              ctr_clr, ctr_adv, at_last;
    logic              buf_load, buf_from_vm;
    logic [ADDR_W-1:0] word_addr;
    logic [WORD_W-1:0] buf_word, buf_in;

    cbs_word_ctr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .adv(ctr_adv),
        .addr_o(word_addr), .last_o(at_last)
    );

    assign buf_in = buf_from_vm ? vm_rdata_i : nv_rdata_i;

    cbs_word_buf #(.WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(buf_load), .d_i(buf_in), .q_o(buf_word)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctr_clr     = 1'b0;
        ctr_adv     = 1'b0;
        buf_load    = 1'b0;
        buf_from_vm = 1'b0;
        unique case (ctl_q.state)
            ST_BOOT: if (pwr_good_i) begin
                if (!mk_present_i) begin
                    ctl_d.state = ST_IDLE;
                end else if (!host_cke_i) begin
                    ctl_d.state = ST_RS_RD;
                    ctr_clr     = 1'b1;
                end
            end
            ST_IDLE: if (!pwr_good_i)
                ctl_d.state = dirty_n_i ? ST_OFF : ST_HOLD;
            ST_OFF: if (pwr_good_i) ctl_d.state = ST_BOOT;
            ST_HOLD: if (!host_cke_i) begin
                ctl_d.state = ST_BK_RD;
                ctr_clr     = 1'b1;
            end
            ST_BK_RD: if (vm_ack_i) begin
                buf_load    = 1'b1;
                buf_from_vm = 1'b1;
                ctl_d.state = ST_BK_WR;
            end
            ST_BK_WR: if (nv_ack_i) begin
                if (at_last) begin
                    ctl_d.state = ST_BK_MARK;
                end else begin
                    ctr_adv     = 1'b1;
                    ctl_d.state = ST_BK_RD;
                end
            end
            ST_BK_MARK: if (mk_ack_i) ctl_d.state = ST_BK_END;
            ST_BK_END:  if (pwr_good_i) ctl_d.state = ST_BOOT;
            ST_RS_RD: if (nv_ack_i) begin
                buf_load    = 1'b1;
                ctl_d.state = ST_RS_WR;
            end
            ST_RS_WR: if (vm_ack_i) begin
                if (at_last) begin
                    ctl_d.state = ST_RS_CLR;
                end else begin
                    ctr_adv     = 1'b1;
                    ctl_d.state = ST_RS_RD;
                end
            end
            ST_RS_CLR: if (mk_ack_i) ctl_d.state = ST_IDLE;
            default:   ctl_d.state = ST_BOOT;
        endcase
        ctl_d.own = ctl_d.state inside {ST_BK_RD, ST_BK_WR, ST_BK_MARK,
                                        ST_RS_RD, ST_RS_WR, ST_RS_CLR};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_BOOT, own: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign bus_oe_o   = ctl_q.own;
    assign done_o     = (ctl_q.state == ST_IDLE);
    assign vm_req_o   = ctl_q.state inside {ST_BK_RD, ST_RS_WR};
    assign vm_we_o    = (ctl_q.state == ST_RS_WR);
    assign vm_addr_o  = word_addr;
    assign vm_wdata_o = buf_word;
    assign nv_req_o   = ctl_q.state inside {ST_BK_WR, ST_RS_RD};
    assign nv_we_o    = (ctl_q.state == ST_BK_WR);
    assign nv_addr_o  = word_addr;
    assign nv_wdata_o = buf_word;
    assign mk_req_o   = ctl_q.state inside {ST_BK_MARK, ST_RS_CLR};
    assign mk_val_o   = (ctl_q.state == ST_BK_MARK);

    // R1: an idle block moves nothing and leaves the bus alone
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!bus_oe_o && !vm_req_o && !nv_req_o && !mk_req_o));

    // R2: no request while the bus drivers are in high impedance
    p_hiz_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> !(vm_req_o || nv_req_o || mk_req_o));

    // R3: ownership is taken only after the host dropped clock-enable
    p_cke_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> !$past(host_cke_i));

    // R5: address steps only after the write handshake of the word
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && $past(bus_oe_o) && !$stable(vm_addr_o)) |->
        ($past(nv_ack_i && nv_we_o) || $past(vm_ack_i && vm_we_o)));

    // R6: backup write word equals the word just read
    p_bk_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nv_req_o) && nv_we_o) |-> (nv_wdata_o == $past(vm_rdata_i)));

    // R6: restore write word equals the word just read
    p_rs_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vm_req_o) && vm_we_o) |-> (vm_wdata_o == $past(nv_rdata_i)));

    // R8: marker set follows the last word write
    p_mark_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mk_req_o) && mk_val_o) |-> ($past(nv_ack_i) && vm_addr_o == LAST_W));
endmodule

// File: tb/cache_backup_seq_test.sv
module cache_backup_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int LAST       = 9;
    localparam int WORD_W     = 72;
    localparam int K_VMR = 0, K_VMW = 1, K_NVR = 2, K_NVW = 3, K_MK = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic pwr_good_i, host_cke_i, dirty_n_i;
    logic bus_oe_o, done_o;
    logic vm_req_o, vm_we_o, nv_req_o, nv_we_o, mk_req_o, mk_val_o;
    logic [ADDR_W-1:0] vm_addr_o, nv_addr_o;
    logic [WORD_W-1:0] vm_wdata_o, nv_wdata_o;
    logic vm_ack_i = 1'b0, nv_ack_i = 1'b0, mk_ack_i = 1'b0;
    logic [WORD_W-1:0] vm_rdata_i = '0, nv_rdata_i = '0;
    logic mk_present_i;

    logic [WORD_W-1:0] dram [0:LAST];
    logic [WORD_W-1:0] flash[0:LAST];
    logic marker;

    int n_cmp = 0, n_bad = 0;
    int vm_wait = -1, nv_wait = -1, mk_wait = -1;
    bit finished = 1'b0;
    logic prev_oe = 1'b0, prev_cke = 1'b1;

    int               q_kind[$];
    int               q_addr[$];
    logic [WORD_W-1:0] q_data[$];
    string            q_tag[$];

    assign mk_present_i = marker;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_backup_seq #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST), .WORD_W(WORD_W)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i), .host_cke_i(host_cke_i),
        .dirty_n_i(dirty_n_i), .bus_oe_o(bus_oe_o), .done_o(done_o),
        .vm_req_o(vm_req_o), .vm_we_o(vm_we_o), .vm_addr_o(vm_addr_o),
        .vm_wdata_o(vm_wdata_o), .vm_ack_i(vm_ack_i), .vm_rdata_i(vm_rdata_i),
        .nv_req_o(nv_req_o), .nv_we_o(nv_we_o), .nv_addr_o(nv_addr_o),
        .nv_wdata_o(nv_wdata_o), .nv_ack_i(nv_ack_i), .nv_rdata_i(nv_rdata_i),
        .mk_req_o(mk_req_o), .mk_val_o(mk_val_o), .mk_ack_i(mk_ack_i),
        .mk_present_i(mk_present_i)
    );

    function automatic logic [WORD_W-1:0] pat(int a, int s);
        return {8'(a * 29 + s * 7 + 3), 32'(32'h9E37_79B9 * (a + 1) + s), 32'(a ^ (s << 12))};
    endfunction

    task automatic chk(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void push(int k, int a, logic [WORD_W-1:0] d, string tag);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
    endfunction

    // transaction compare against the expected order
    task automatic seen(int k, int a, logic [WORD_W-1:0] d);
        if (q_kind.size() == 0) begin
            chk(1'b0, "R7/R10 unexpected transaction", WORD_W'(k), WORD_W'(99));
        end else begin
            int ek = q_kind.pop_front();
            int ea = q_addr.pop_front();
            logic [WORD_W-1:0] ed = q_data.pop_front();
            string t = q_tag.pop_front();
            bit is_wr = (k == K_VMW || k == K_NVW || k == K_MK);
            chk(ek == k, {t, " kind"}, WORD_W'(k), WORD_W'(ek));
            chk(ea == a, {t, " address"}, WORD_W'(a), WORD_W'(ea));
            if (is_wr) chk(ed == d, {t, " data"}, d, ed);
        end
    endtask

    function automatic void expect_backup(int s);
        for (int a = 0; a <= LAST; a++) begin
            push(K_VMR, a, '0, "R4/R5 backup read");
            push(K_NVW, a, pat(a, s), "R6 backup write");
        end
        push(K_MK, 0, WORD_W'(1), "R8 marker set");
    endfunction

    function automatic void expect_restore(int s);
        for (int a = 0; a <= LAST; a++) begin
            push(K_NVR, a, '0, "R9 restore read");
            push(K_VMW, a, pat(a, s), "R9 restore write");
        end
        push(K_MK, 0, WORD_W'(0), "R9 marker clear");
    endfunction

    // memory responders: variable latency, single-cycle acknowledge
    always @(negedge clk) begin
        vm_ack_i = 1'b0; nv_ack_i = 1'b0; mk_ack_i = 1'b0;
        if (!vm_req_o) vm_wait = -1;
        else begin
            if (vm_wait < 0) vm_wait = int'(vm_addr_o) % 3;
            if (vm_wait == 0) begin
                vm_ack_i = 1'b1; vm_wait = -2;
                if (vm_we_o) begin
                    dram[vm_addr_o] = vm_wdata_o;
                    seen(K_VMW, int'(vm_addr_o), vm_wdata_o);
                end else begin
                    vm_rdata_i = dram[vm_addr_o];
                    seen(K_VMR, int'(vm_addr_o), '0);
                end
            end else if (vm_wait > 0) vm_wait--;
        end
        if (!nv_req_o) nv_wait = -1;
        else begin
            if (nv_wait < 0) nv_wait = (int'(nv_addr_o) + 1) % 4;
            if (nv_wait == 0) begin
                nv_ack_i = 1'b1; nv_wait = -2;
                if (nv_we_o) begin
                    flash[nv_addr_o] = nv_wdata_o;
                    seen(K_NVW, int'(nv_addr_o), nv_wdata_o);
                end else begin
                    nv_rdata_i = flash[nv_addr_o];
                    seen(K_NVR, int'(nv_addr_o), '0);
                end
            end else if (nv_wait > 0) nv_wait--;
        end
        if (!mk_req_o) mk_wait = -1;
        else begin
            if (mk_wait < 0) mk_wait = 2;
            if (mk_wait == 0) begin
                mk_ack_i = 1'b1; mk_wait = -2;
                marker = mk_val_o;
                seen(K_MK, 0, WORD_W'(mk_val_o));
            end else if (mk_wait > 0) mk_wait--;
        end
    end

    // per-clock ownership checks
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!((vm_req_o || nv_req_o || mk_req_o) && !bus_oe_o), "R2 request while hi-z",
                WORD_W'(bus_oe_o), WORD_W'(1));
            chk(!(done_o && (bus_oe_o || vm_req_o || nv_req_o || mk_req_o)), "R1 activity while done",
                WORD_W'(bus_oe_o), WORD_W'(0));
            if (bus_oe_o && !prev_oe)
                chk(!prev_cke, "R3 bus taken with cke high", WORD_W'(prev_cke), WORD_W'(0));
        end
        prev_oe  = bus_oe_o;
        prev_cke = host_cke_i;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < 2000 && q_kind.size() > 0; i++) @(negedge clk);
        chk(q_kind.size() == 0, {tag, " transfer incomplete"}, WORD_W'(q_kind.size()), WORD_W'(0));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", '0, '0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pwr_good_i = 1'b1; host_cke_i = 1'b1; dirty_n_i = 1'b1; marker = 1'b0;
        for (int a = 0; a <= LAST; a++) begin dram[a] = pat(a, 1); flash[a] = '0; end
        cyc(4);
        chk(bus_oe_o == 1'b0, "R2 reset hi-z", WORD_W'(bus_oe_o), '0);
        rst_n = 1'b1;
        cyc(3);
        chk(done_o == 1'b1, "R10 no image, straight to idle", WORD_W'(done_o), WORD_W'(1));
        chk(bus_oe_o == 1'b0, "R1 idle hi-z", WORD_W'(bus_oe_o), '0);
        cyc(10);

        // dirty power loss, host still driving for a while
        dirty_n_i = 1'b0; pwr_good_i = 1'b0;
        expect_backup(1);
        cyc(6);
        chk(bus_oe_o == 1'b0, "R3 waits for cke low", WORD_W'(bus_oe_o), '0);
        chk(done_o == 1'b0, "R1 done drops on power loss", WORD_W'(done_o), '0);
        host_cke_i = 1'b0;
        drain("R4");
        cyc(2);
        chk(marker == 1'b1, "R8 marker present", WORD_W'(marker), WORD_W'(1));
        chk(bus_oe_o == 1'b0, "R2 released after backup", WORD_W'(bus_oe_o), '0);
        for (int a = 0; a <= LAST; a++)
            chk(flash[a] == pat(a, 1), "R6 saved image", flash[a], pat(a, 1));

        // power returns, restore waits for cke low
        for (int a = 0; a <= LAST; a++) dram[a] = '0;
        host_cke_i = 1'b1; pwr_good_i = 1'b1;
        cyc(6);
        chk(bus_oe_o == 1'b0, "R3 restore waits for cke low", WORD_W'(bus_oe_o), '0);
        chk(done_o == 1'b0, "R9 no done before restore", WORD_W'(done_o), '0);
        expect_restore(1);
        host_cke_i = 1'b0;
        drain("R9");
        cyc(2);
        chk(done_o == 1'b1, "R9 done after restore", WORD_W'(done_o), WORD_W'(1));
        chk(marker == 1'b0, "R9 marker cleared", WORD_W'(marker), '0);
        for (int a = 0; a <= LAST; a++)
            chk(dram[a] == pat(a, 1), "R9 restored image", dram[a], pat(a, 1));

        // clean power loss: nothing moves
        host_cke_i = 1'b1; dirty_n_i = 1'b1; cyc(2);
        pwr_good_i = 1'b0; cyc(2);
        host_cke_i = 1'b0; cyc(20);
        chk(bus_oe_o == 1'b0, "R7 clean loss keeps hi-z", WORD_W'(bus_oe_o), '0);
        chk(done_o == 1'b0, "R7 clean loss drops done", WORD_W'(done_o), '0);
        pwr_good_i = 1'b1; cyc(4);
        chk(done_o == 1'b1, "R10 clean return to idle", WORD_W'(done_o), WORD_W'(1));
        chk(marker == 1'b0, "R7 marker untouched", WORD_W'(marker), '0);

        // dirty loss, power comes back mid-backup
        for (int a = 0; a <= LAST; a++) dram[a] = pat(a, 2);
        host_cke_i = 1'b1; dirty_n_i = 1'b0; cyc(2);
        pwr_good_i = 1'b0;
        expect_backup(2);
        expect_restore(2);
        cyc(2);
        host_cke_i = 1'b0;
        for (int i = 0; i < 500 && q_kind.size() > 4 * (LAST + 1) + 2 - 5; i++) @(negedge clk);
        pwr_good_i = 1'b1;
        drain("R11");
        cyc(2);
        chk(done_o == 1'b1, "R11 done after backup and restore", WORD_W'(done_o), WORD_W'(1));
        chk(marker == 1'b0, "R11 marker cleared", WORD_W'(marker), '0);
        for (int a = 0; a <= LAST; a++)
            chk(flash[a] == pat(a, 2), "R11 full image saved", flash[a], pat(a, 2));
        cyc(5);
        finish_run();
    end
endmodule